// File: doc/BRIEF.md
# Two-Stage Sinc Decimator (Fourth-Order Front, Boxcar Back)

This block turns a multi-bit delta-sigma modulator sample stream into decimated, gain-normalised signed results. A fourth-order sinc decimator always divides the rate by 32. It is followed by a first-order accumulate-and-dump stage whose ratio B is picked by a select code. The total oversampling ratio is therefore 32·B. The product of the two responses holds a boxcar that is exactly as long as the output period. As a result, every integer multiple of the output rate is an exact null. Settling also takes fewer samples than a single fourth-order stage with the same total ratio.

Samples enter on a modulator-rate strobe (`in_valid`) in a single clock domain. The input has no back-pressure: the block takes every sample presented with `in_valid` high and has no ready signal. Each result is offered with a one-cycle `out_valid` pulse, and the consumer must capture it in that cycle because the result is not held for later. After a restart, or a change of the select code, the block reports only fully settled results. Typical use is a fixed select code with a continuous stream of samples. The select code is changed only when a different output rate is wanted.

Top module: `sinc_cascade_decim`

## Requirements
- R1: The first stage produces exactly one result per 32 accepted samples, whatever the select code.
- R2: Select codes 0 to 8 pick second-stage ratios 2, 4, 10, 20, 40, 100, 200, 400 and 1000 respectively. Codes 9 to 15 pick ratio 2.
- R3: While running, consecutive `out_valid` pulses are separated by exactly 32·B accepted samples.
- R4: A constant input x gives settled results within ±1 LSB of x·2^(OUT_W−IN_W), for every ratio. This is x·2^20 with the default widths.
- R5: A zero-mean input that repeats every 32·B samples gives settled results of exactly 0.
- R6: After a restart, the first result is the one completed by accepted sample number 32·(B+3). This is fewer samples than the 4·32·B needed by a single fourth-order stage.
- R7: `out_valid` is high for one cycle only, in the third cycle after the cycle that carries the completing sample.
- R8: When `start` is high, all filter state is cleared and the sample in that cycle is discarded. `out_valid` stays low until the filter has refilled as in R6.
- R9: A change of `osr_sel` from the value seen in the previous cycle acts exactly like `start`.
- R10: Cycles with `in_valid` low change no filter state, whatever `in_data` holds.
- R11: A result beyond the signed OUT_W range is clamped to −2^(OUT_W−1) or 2^(OUT_W−1)−1. For example, constant −8 at ratio 10 yields exactly −8388608.
- R12: During and right after reset, `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous restart of the filter |
| osr_sel | input | 4 | Second-stage ratio select code |
| in_valid | input | 1 | Modulator-rate sample strobe |
| in_data | input | IN_W (4) | Signed modulator sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | OUT_W (24) | Signed, normalised, saturated result |

## Verification
The pipeline has three registers between the input and the output: the first-stage result, the second-stage sum, and the scaled output. A result is therefore due in the third cycle after the cycle carrying its completing sample. The bench logs the cycle number of each accepted sample and of each output pulse, both sampled on the falling edge. It compares the first pulse against the cycle of sample 32·(B+3) plus three, and the spacing between pulses against 32·B times the strobe spacing. For restart and select-change tests, the bench stops feeding one sample short of a refill, confirms that no pulse has appeared, and then checks that exactly one pulse follows the next sample.

// File: rtl/sincd_pkg.sv
package sincd_pkg;

  // Second-stage ratio for a select code; undefined codes fall back to 2.
  function automatic int unsigned ratio_of(input int code);
    case (code)
      0: return 2;
      1: return 4;
      2: return 10;
      3: return 20;
      4: return 40;
      5: return 100;
      6: return 200;
      7: return 400;
      8: return 1000;
      default: return 2;
    endcase
  endfunction

  // Normalising multiplier ceil(2^sh / b).
  function automatic longint unsigned norm_mult(input int unsigned b, input int sh);
    longint unsigned one_sh;
    one_sh = 64'd1 << sh;
    return (one_sh + 64'(b) - 64'd1) / 64'(b);
  endfunction

endpackage

// File: rtl/sincd_cic4.sv
module sincd_cic4 #(
  parameter int IN_W  = 4,
  parameter int DEC   = 32,
  parameter int ORDER = 4,
  parameter int IW    = IN_W + ORDER * $clog2(DEC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 in_vld,
  input  logic signed [IN_W-1:0] in_dat,
  output logic                 out_vld,
  output logic signed [IW-1:0] out_dat
);
  localparam int PW = $clog2(DEC);

  logic signed [IW-1:0] integ_q [ORDER];
  logic signed [IW-1:0] integ_d [ORDER];
  logic signed [IW-1:0] dly_q   [ORDER];
  logic signed [IW-1:0] diff_d  [ORDER];
  logic signed [IW-1:0] x_ext;
  logic [PW-1:0]        phase_q;
  logic                 last;

  assign x_ext = {{(IW-IN_W){in_dat[IN_W-1]}}, in_dat};
  assign last  = (phase_q == PW'(DEC-1));

  // integrator chain then comb chain, both wrap-around
  always_comb begin
    integ_d[0] = integ_q[0] + x_ext;
    for (int k = 1; k < ORDER; k++) integ_d[k] = integ_q[k] + integ_d[k-1];
    diff_d[0] = integ_d[ORDER-1] - dly_q[0];
    for (int k = 1; k < ORDER; k++) diff_d[k] = diff_d[k-1] - dly_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ORDER; k++) begin integ_q[k] <= '0; dly_q[k] <= '0; end
      phase_q <= '0;
      out_vld <= 1'b0;
      out_dat <= '0;
    end else if (clr) begin
      for (int k = 0; k < ORDER; k++) begin integ_q[k] <= '0; dly_q[k] <= '0; end
      phase_q <= '0;
      out_vld <= 1'b0;
      out_dat <= '0;
    end else begin
      out_vld <= 1'b0;
      if (in_vld) begin
        for (int k = 0; k < ORDER; k++) integ_q[k] <= integ_d[k];
        phase_q <= last ? '0 : phase_q + 1'b1;
        if (last) begin
          dly_q[0] <= integ_d[ORDER-1];
          for (int k = 1; k < ORDER; k++) dly_q[k] <= diff_d[k-1];
          out_dat <= diff_d[ORDER-1];
          out_vld <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sincd_box.sv
module sincd_box #(
  parameter int IW   = 24,
  parameter int SW   = 34,
  parameter int BW   = 10,
  parameter int WARM = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [BW-1:0]        ratio,
  input  logic                 in_vld,
  input  logic signed [IW-1:0] in_dat,
  output logic                 out_vld,
  output logic signed [SW-1:0] out_sum
);
  localparam int WMW = $clog2(WARM + 1);

  logic [WMW-1:0]       warm_q;
  logic [BW-1:0]        cnt_q;
  logic signed [SW-1:0] acc_q;
  logic signed [SW-1:0] d_ext;

  assign d_ext = {{(SW-IW){in_dat[IW-1]}}, in_dat};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0; cnt_q <= '0; acc_q <= '0; out_vld <= 1'b0; out_sum <= '0;
    end else if (clr) begin
      warm_q <= '0; cnt_q <= '0; acc_q <= '0; out_vld <= 1'b0; out_sum <= '0;
    end else begin
      out_vld <= 1'b0;
      if (in_vld) begin
        if (warm_q != WMW'(WARM)) begin
          warm_q <= warm_q + 1'b1;       // first-stage results not yet settled
        end else if (cnt_q == ratio - BW'(1)) begin
          out_sum <= acc_q + d_ext;
          acc_q   <= '0;
          cnt_q   <= '0;
          out_vld <= 1'b1;
        end else begin
          acc_q <= acc_q + d_ext;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sincd_norm.sv
module sincd_norm #(
  parameter int SW     = 34,
  parameter int MW     = 34,
  parameter int OUT_W  = 24,
  parameter int SH_TOT = 34
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    in_vld,
  input  logic signed [SW-1:0]    in_sum,
  input  logic [MW-1:0]           mult,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] out_dat
);
  localparam int PW = SW + MW + 1;

  logic signed [PW-1:0] sum_s, mul_s, prod, shv, hi, lo;
  logic signed [OUT_W-1:0] sat;

  always_comb begin
    sum_s = {{(PW-SW){in_sum[SW-1]}}, in_sum};
    mul_s = {{(PW-MW){1'b0}}, mult};
    prod  = sum_s * mul_s;
    shv   = prod >>> SH_TOT;
    hi    = '0;
    hi[OUT_W-1:0] = {1'b0, {(OUT_W-1){1'b1}}};
    lo    = ~hi;
    if (shv > hi)      sat = hi[OUT_W-1:0];
    else if (shv < lo) sat = lo[OUT_W-1:0];
    else               sat = shv[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0; out_dat <= '0;
    end else if (clr) begin
      out_vld <= 1'b0; out_dat <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_dat <= sat;
    end
  end
endmodule

// File: rtl/sinc_cascade_decim.sv
module sinc_cascade_decim #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 24,
  parameter int SEL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [SEL_W-1:0]        osr_sel,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int DEC1   = 32;
  localparam int ORDER  = 4;
  localparam int IW     = IN_W + ORDER * $clog2(DEC1);
  localparam int BMAX   = 1000;
  localparam int BW     = $clog2(BMAX + 1);
  localparam int SW     = IW + $clog2(BMAX);
  localparam int SH     = 34;
  localparam int MW     = SH;
  localparam int SH_TOT = SH + IW - OUT_W;
  localparam int NSEL   = 2 ** SEL_W;

  logic [BW-1:0]  ratio_tab [NSEL];
  logic [MW-1:0]  mult_tab  [NSEL];
  logic [SEL_W-1:0] osr_q;
  logic           restart;
  logic           s4_vld, s1_vld;
  logic signed [IW-1:0] s4_dat;
  logic signed [SW-1:0] s1_sum;

  for (genvar g = 0; g < NSEL; g++) begin : g_tab
    assign ratio_tab[g] = BW'(sincd_pkg::ratio_of(g));
    assign mult_tab[g]  = MW'(sincd_pkg::norm_mult(sincd_pkg::ratio_of(g), SH));
  end

  assign restart = start | (osr_sel != osr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osr_q <= '0;
    else        osr_q <= osr_sel;
  end

  sincd_cic4 #(.IN_W(IN_W), .DEC(DEC1), .ORDER(ORDER), .IW(IW)) u_s4 (
    .clk(clk), .rst_n(rst_n), .clr(restart),
    .in_vld(in_valid), .in_dat(in_data),
    .out_vld(s4_vld), .out_dat(s4_dat)
  );

  sincd_box #(.IW(IW), .SW(SW), .BW(BW), .WARM(ORDER-1)) u_s1 (
    .clk(clk), .rst_n(rst_n), .clr(restart), .ratio(ratio_tab[osr_q]),
    .in_vld(s4_vld), .in_dat(s4_dat),
    .out_vld(s1_vld), .out_sum(s1_sum)
  );

  sincd_norm #(.SW(SW), .MW(MW), .OUT_W(OUT_W), .SH_TOT(SH_TOT)) u_nrm (
    .clk(clk), .rst_n(rst_n), .clr(restart),
    .in_vld(s1_vld), .in_sum(s1_sum), .mult(mult_tab[osr_q]),
    .out_vld(out_valid), .out_dat(out_data)
  );
endmodule

// File: rtl/sincd_chk.sv
module sincd_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [SEL_W-1:0] osr_sel,
  input logic             out_valid,
  input logic             s4_vld
);
  // R7
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_valid);

  // R9
  sel_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osr_sel != $past(osr_sel)) |=> !out_valid);

  // R1
  s4_sparse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s4_vld |=> !s4_vld);
endmodule

bind sinc_cascade_decim sincd_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .osr_sel(osr_sel),
  .out_valid(out_valid), .s4_vld(s4_vld)
);

// File: tb/sinc_cascade_decim_bench.sv
module sinc_cascade_decim_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] osr_sel = '0;
  logic in_valid = 1'b0;
  logic signed [3:0] in_data = '0;
  logic out_valid;
  logic signed [23:0] out_data;

  int nchk = 0, nerr = 0;
  int cyc = 0, nsamp = 0, tgt = 0, due_cyc = -1, out_n = 0;
  int ov [8];
  int oc [8];

  localparam int VEC_N = 6;
  localparam int V_CODE [VEC_N] = '{0, 1, 2, 3, 4, 8};
  localparam int V_X    [VEC_N] = '{7, -3, 5, -1, -8, 1};
  localparam int V_GAP  [VEC_N] = '{2, 2, 3, 2, 1, 1};

  sinc_cascade_decim u_sinc_cascade_decim (
    .clk(clk), .rst_n(rst_n), .start(start), .osr_sel(osr_sel),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (in_valid) begin
      nsamp++;
      if (nsamp == tgt) due_cyc = cyc + 3;
    end
    if (out_valid) begin
      if (out_n < 8) begin ov[out_n] = int'(out_data); oc[out_n] = cyc; end
      out_n++;
    end
  end

  function automatic int exp_ratio(input int code);
    case (code)
      0: return 2;    1: return 4;    2: return 10;
      3: return 20;   4: return 40;   5: return 100;
      6: return 200;  7: return 400;  8: return 1000;
      default: return 2;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic restart(input int code, input bit use_start);
    osr_sel  = 4'(code);
    start    = use_start;
    in_valid = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    nsamp = 0; out_n = 0; due_cyc = -1;
    tgt = 32 * (exp_ratio(code) + 3);
  endtask

  // mode 0: constant a; mode 1: square +a/-a, half period 'half'
  task automatic feed(input int mode, input int a, input int half, input int gap, input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      if (mode == 0) in_data = 4'(a);
      else in_data = ((i % (2*half)) < half) ? 4'(a) : 4'(-a);
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_data  = 4'(-a - 1);          // junk while strobe low (R10)
      for (int j = 1; j < gap; j++) begin @(posedge clk); #1; end
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    #1;
  endtask

  initial begin
    #(190000 * 8);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check(out_valid == 1'b0, "R12 valid in reset", int'(out_valid), 0);
    check(out_data == '0, "R12 data in reset", int'(out_data), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(out_valid == 1'b0 && out_data == '0, "R12 after reset", int'(out_data), 0);

    // Vector table: DC level per ratio, strobe spacing
    for (int v = 0; v < VEC_N; v++) begin
      int b, osr, ex, d;
      b = exp_ratio(V_CODE[v]);
      osr = 32 * b;
      ex = V_X[v] * (1 << 20);
      restart(V_CODE[v], 1'b1);
      feed(0, V_X[v], 1, V_GAP[v], tgt + osr);
      settle();
      check(out_n == 2, "R3 R6 output count", out_n, 2);
      check(oc[0] == due_cyc, "R6 R7 first result cycle", oc[0], due_cyc);
      check(oc[1] - oc[0] == osr * V_GAP[v], "R1 R3 R10 result spacing", oc[1] - oc[0], osr * V_GAP[v]);
      d = ov[0] - ex;
      check(d >= -1 && d <= 1, "R2 R4 DC first", ov[0], ex);
      d = ov[1] - ex;
      check(d >= -1 && d <= 1, "R4 DC second", ov[1], ex);
    end

    // R5 nulls at OSR 64, period 64
    restart(0, 1'b1);
    feed(1, 6, 32, 2, 160 + 128);
    settle();
    check(out_n == 3, "R5 count", out_n, 3);
    for (int i = 0; i < 3; i++) check(ov[i] == 0, "R5 null osr64", ov[i], 0);

    // R5 nulls at OSR 320
    restart(2, 1'b1);
    feed(1, 7, 160, 1, 416 + 320);
    settle();
    check(out_n == 2 && ov[0] == 0 && ov[1] == 0, "R5 null osr320", ov[0], 0);

    // R11 saturation
    restart(2, 1'b1);
    feed(0, -8, 1, 2, 416);
    settle();
    check(out_n == 1 && ov[0] == -8388608, "R11 clamp low", ov[0], -8388608);

    // R8 restart mid-window
    restart(1, 1'b1);
    feed(0, 3, 1, 2, 200);
    restart(1, 1'b1);
    feed(0, 3, 1, 2, 223);
    settle();
    check(out_n == 0, "R8 no early result", out_n, 0);
    feed(0, 3, 1, 2, 1);
    settle();
    check(out_n == 1 && ov[0] == 3 * (1 << 20), "R8 refill result", ov[0], 3 * (1 << 20));

    // R9 select change without start
    restart(0, 1'b1);
    feed(0, 2, 1, 2, 170);
    settle();
    check(out_n == 1, "R9 pre-change output", out_n, 1);
    restart(1, 1'b0);
    feed(0, 2, 1, 2, 223);
    settle();
    check(out_n == 0, "R9 no early result", out_n, 0);
    feed(0, 2, 1, 2, 1);
    settle();
    check(out_n == 1 && ov[0] == 2 * (1 << 20), "R9 refill result", ov[0], 2 * (1 << 20));

    // R2 undefined code maps to ratio 2
    restart(13, 1'b1);
    feed(0, 2, 1, 2, 160);
    settle();
    check(out_n == 1 && oc[0] == due_cyc, "R2 code13 timing", oc[0], due_cyc);
    check(ov[0] == 2 * (1 << 20), "R2 code13 value", ov[0], 2 * (1 << 20));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule